// File: doc/BRIEF.md
# Supervisory Reset Pulse Controller

This block combines three kinds of reset request into one reset pulse of fixed length. The sources are a digital supply-good flag, a pair of bidirectional reset pins (one active high, one active low) and a watchdog expiry request. The pulse is timed by a slow tick enable. With the defaults, 1000 ticks of a 5 kHz timebase give a 200 ms pulse. While the supply flag is false, both outputs are asserted without waiting for a clock edge.

The reset pins are emulated as open-drain pads. The block drives a pin only while it asserts reset, and it reads the pad level back through a separate input. An external request on either pin is edge-triggered and is filtered against single-sample glitches. Such a request is therefore cleaned up and stretched to the full pulse, however short or long it was. While the block drives the pins, their read-back is masked, so the block's own drive never restarts the pulse. A new request that arrives while a pulse is running reloads the pulse to its full length.

Top module: `rstp_ctrl`

## Requirements
- R1: While `supply_ok` is 0, `rst_out`=1, `rstn_out`=0 and both output enables are 1, in the same cycle and without waiting for a clock edge.
- R2: After `supply_ok` goes to 1, the outputs stay asserted for exactly `PULSE_TICKS` cycles with `tick_en`=1, and are then released.
- R3: When `rst_pin_in` reads 1 on `GLITCH_SAMPLES` consecutive clock edges after having read 0, a full pulse starts. The outputs assert after the following edge and hold for `PULSE_TICKS` ticks.
- R4: When `rstn_pin_in` reads 0 on `GLITCH_SAMPLES` consecutive clock edges after having read 1, a full pulse starts with the same timing as in R3.
- R5: `wdog_expire`=1 at a clock edge loads the full count, so the outputs are asserted after that edge.
- R6: A pin that is active for fewer than `GLITCH_SAMPLES` consecutive samples starts no pulse.
- R7: A request that arrives during a pulse reloads the count, so the outputs stay asserted for `PULSE_TICKS` ticks counted from that request.
- R8: When a pulse ends and no external request is present, the outputs stay released. The block's own pin drive does not restart the pulse.
- R9: `rstn_out` is always the inverse of `rst_out`. Both output enables equal `rst_out`: 1 while reset is asserted and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| tick_en | input | 1 | Slow timebase tick, one clock wide |
| supply_ok | input | 1 | Supply-good flag; 0 acts as the block's reset |
| rst_pin_in | input | 1 | Read-back of the active-high reset pad |
| rstn_pin_in | input | 1 | Read-back of the active-low reset pad |
| wdog_expire | input | 1 | Watchdog timeout request |
| rst_out | output | 1 | Active-high reset value |
| rst_oe | output | 1 | Drive enable for the active-high pad |
| rstn_out | output | 1 | Active-low reset value |
| rstn_oe | output | 1 | Drive enable for the active-low pad |

## Verification
The properties treat `supply_ok` low as the block's reset. They assume the pad read-back follows the block's own drive whenever an enable is set, as a real open-drain pad would. The self-retrigger property further assumes that no watchdog request coincides with the end of a pulse. The bench models each pad as the driven value when enabled and the external level otherwise. The external levels change only after a clock edge. Watchdog requests in the random phase are rare, and a property that needs their absence is qualified on that input.

// File: rtl/rstp_pkg.sv
package rstp_pkg;

   // Which pad level means "reset requested"
   typedef enum logic {
      POL_ACT_HIGH = 1'b0,
      POL_ACT_LOW  = 1'b1
   } pin_pol_e;

   // Bits needed to hold the values 0..n
   function automatic int unsigned count_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/rstp_edge_filter.sv
module rstp_edge_filter #(
   parameter rstp_pkg::pin_pol_e POL     = rstp_pkg::POL_ACT_HIGH,
   parameter int unsigned        SAMPLES = 2
) (
   input  logic clk,
   input  logic clear,
   input  logic pin,
   output logic trig
);
   logic               act;
   logic [SAMPLES-1:0] hist;
   logic               filt;

   generate
      if (SAMPLES < 2) begin : g_bad_samples
         $error("rstp_edge_filter: SAMPLES must be at least 2");
      end
      if (POL == rstp_pkg::POL_ACT_HIGH) begin : g_act_high
         assign act = pin;
      end else begin : g_act_low
         assign act = ~pin;
      end
   endgenerate

   // The history only changes the filtered level when every sample agrees
   always_ff @(posedge clk) begin
      if (clear) begin
         hist <= '0;
         filt <= 1'b0;
      end else begin
         hist <= {hist[SAMPLES-2:0], act};
         if (&hist)
            filt <= 1'b1;
         else if (~|hist)
            filt <= 1'b0;
      end
   end

   // A request is the moment the filtered level is about to turn active
   assign trig = ~clear & ~filt & (&hist);

endmodule

// File: rtl/rstp_stretch.sv
module rstp_stretch #(
   parameter int unsigned PULSE_TICKS = 1000
) (
   input  logic clk,
   input  logic supply_ok,
   input  logic load,
   input  logic tick_en,
   output logic active
);
   localparam int unsigned   CW   = rstp_pkg::count_bits(PULSE_TICKS);
   localparam logic [CW-1:0] FULL = CW'(PULSE_TICKS);
   localparam logic [CW-1:0] ONE  = CW'(1);

   logic [CW-1:0] cnt;

   generate
      if (PULSE_TICKS < 1) begin : g_bad_ticks
         $error("rstp_stretch: PULSE_TICKS must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!supply_ok)
         cnt <= FULL;
      else if (load)
         cnt <= FULL;
      else if (tick_en && (cnt != '0))
         cnt <= cnt - ONE;
   end

   assign active = ~supply_ok | (cnt != '0);

endmodule

// File: rtl/rstp_ctrl.sv
module rstp_ctrl #(
   parameter int unsigned PULSE_TICKS    = 1000,
   parameter int unsigned GLITCH_SAMPLES = 2
) (
   input  logic clk,
   input  logic tick_en,
   input  logic supply_ok,
   input  logic rst_pin_in,
   input  logic rstn_pin_in,
   input  logic wdog_expire,
   output logic rst_out,
   output logic rst_oe,
   output logic rstn_out,
   output logic rstn_oe
);
   logic active;
   logic trig_hi;
   logic trig_lo;
   logic load;

   // Read-back is masked while the block drives the pads
   rstp_edge_filter #(
      .POL     (rstp_pkg::POL_ACT_HIGH),
      .SAMPLES (GLITCH_SAMPLES)
   ) u_filt_hi (
      .clk   (clk),
      .clear (active),
      .pin   (rst_pin_in),
      .trig  (trig_hi)
   );

   rstp_edge_filter #(
      .POL     (rstp_pkg::POL_ACT_LOW),
      .SAMPLES (GLITCH_SAMPLES)
   ) u_filt_lo (
      .clk   (clk),
      .clear (active),
      .pin   (rstn_pin_in),
      .trig  (trig_lo)
   );

   assign load = trig_hi | trig_lo | wdog_expire;

   rstp_stretch #(
      .PULSE_TICKS (PULSE_TICKS)
   ) u_stretch (
      .clk       (clk),
      .supply_ok (supply_ok),
      .load      (load),
      .tick_en   (tick_en),
      .active    (active)
   );

   assign rst_out  = active;
   assign rst_oe   = active;
   assign rstn_out = ~active;
   assign rstn_oe  = active;

endmodule

// File: rtl/rstp_checker.sv
module rstp_checker (
   input logic clk,
   input logic supply_ok,
   input logic tick_en,
   input logic wdog_expire,
   input logic rst_out,
   input logic rst_oe,
   input logic rstn_out,
   input logic rstn_oe
);

   assert_supply_low_R1: assert property (@(posedge clk)
      !supply_ok |-> (rst_out && rst_oe && !rstn_out && rstn_oe));

   assert_release_on_tick_R2: assert property (@(posedge clk) disable iff (!supply_ok)
      $fell(rst_out) |-> $past(tick_en));

   assert_wdog_load_R5: assert property (@(posedge clk) disable iff (!supply_ok)
      wdog_expire |=> rst_out);

   assert_no_self_retrigger_R8: assert property (@(posedge clk) disable iff (!supply_ok)
      ($fell(rst_out) && !wdog_expire) |=> !rst_out);

   assert_complementary_R9: assert property (@(posedge clk)
      (rstn_out == !rst_out) && (rst_oe == rst_out) && (rstn_oe == rst_out));

endmodule

bind rstp_ctrl rstp_checker u_chk (
   .clk         (clk),
   .supply_ok   (supply_ok),
   .tick_en     (tick_en),
   .wdog_expire (wdog_expire),
   .rst_out     (rst_out),
   .rst_oe      (rst_oe),
   .rstn_out    (rstn_out),
   .rstn_oe     (rstn_oe)
);

// File: tb/rstp_ctrl_bench.sv
module rstp_ctrl_bench;
   localparam int PT   = 20;
   localparam int GS   = 2;
   localparam int TDIV = 3;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic tick_en   = 1'b0;
   logic supply_ok = 1'b0;
   logic ext_h     = 1'b0;
   logic ext_l     = 1'b1;
   logic wdog      = 1'b0;
   logic rst_out, rst_oe, rstn_out, rstn_oe;
   logic pin_h, pin_l;

   // Open-drain pads: the driven value wins while enabled
   assign pin_h = rst_oe  ? rst_out  : ext_h;
   assign pin_l = rstn_oe ? rstn_out : ext_l;

   rstp_ctrl #(.PULSE_TICKS(PT), .GLITCH_SAMPLES(GS)) u_rstp_ctrl (
      .clk         (clk),
      .tick_en     (tick_en),
      .supply_ok   (supply_ok),
      .rst_pin_in  (pin_h),
      .rstn_pin_in (pin_l),
      .wdog_expire (wdog),
      .rst_out     (rst_out),
      .rst_oe      (rst_oe),
      .rstn_out    (rstn_out),
      .rstn_oe     (rstn_oe)
   );

   int checks = 0;
   int errors = 0;
   int asrt_ticks = 0;
   int tdiv = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // Slow tick: one clock in TDIV
   always @(posedge clk) begin
      #1;
      tdiv = (tdiv + 1) % TDIV;
      tick_en = (tdiv == 0);
   end

   // Behavioural reference model
   int m_cnt = 0;
   int h_ones = 0, h_zeros = 0, l_ones = 0, l_zeros = 0;
   bit h_filt = 0, l_filt = 0;
   bit model_ok = 0;

   always @(posedge clk) begin
      bit asrt, eh, el, trig;
      asrt = !supply_ok || (m_cnt != 0);
      eh = !asrt && !h_filt && (h_ones >= GS);
      el = !asrt && !l_filt && (l_ones >= GS);
      trig = eh || el || (wdog === 1'b1);
      if (asrt) begin
         h_ones = 0; h_zeros = GS; h_filt = 0;
         l_ones = 0; l_zeros = GS; l_filt = 0;
      end else begin
         if (h_ones >= GS) h_filt = 1; else if (h_zeros >= GS) h_filt = 0;
         if (l_ones >= GS) l_filt = 1; else if (l_zeros >= GS) l_filt = 0;
         if (pin_h === 1'b1) begin h_ones = (h_ones < GS) ? h_ones + 1 : GS; h_zeros = 0; end
         else begin h_zeros = (h_zeros < GS) ? h_zeros + 1 : GS; h_ones = 0; end
         if (pin_l === 1'b0) begin l_ones = (l_ones < GS) ? l_ones + 1 : GS; l_zeros = 0; end
         else begin l_zeros = (l_zeros < GS) ? l_zeros + 1 : GS; l_ones = 0; end
      end
      if (!supply_ok) m_cnt = PT;
      else if (trig) m_cnt = PT;
      else if (tick_en && m_cnt != 0) m_cnt--;
      model_ok = 1;
   end

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      bit exp;
      if (model_ok && !done) begin
         exp = !supply_ok || (m_cnt != 0);
         chk(rst_out === exp, "R2", "per-cycle rst_out", int'(rst_out), int'(exp));
         chk((rstn_out === !exp) && (rst_oe === exp) && (rstn_oe === exp), "R9",
             "per-cycle rstn_out", int'(rstn_out), int'(!exp));
      end
   end

   always @(negedge clk)
      if (rst_out === 1'b1 && tick_en) asrt_ticks++;

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wait_release(output int ticks);
      @(negedge clk);
      while (rst_out !== 1'b0) @(negedge clk);
      ticks = asrt_ticks;
      @(posedge clk);
      #1;
   endtask

   initial begin
      int t;
      step(8);
      @(negedge clk);
      chk(rst_out === 1 && rstn_out === 0 && rst_oe === 1 && rstn_oe === 1, "R1",
          "reset state while supply low", int'(rst_out), 1);
      step(1);
      supply_ok = 1'b1;
      asrt_ticks = 0;
      wait_release(t);
      chk(t == PT, "R2", "power-up pulse ticks", t, PT);

      step(30);
      @(negedge clk);
      chk(rst_out === 0, "R8", "idle after pulse", int'(rst_out), 0);

      // R6: single-sample glitches on both pads
      step(1); ext_h = 1'b1; step(1); ext_h = 1'b0; step(10);
      @(negedge clk);
      chk(rst_out === 0, "R6", "glitch on high pad", int'(rst_out), 0);
      step(1); ext_l = 1'b0; step(1); ext_l = 1'b1; step(10);
      @(negedge clk);
      chk(rst_out === 0, "R6", "glitch on low pad", int'(rst_out), 0);

      // R3: high pad request
      step(1); asrt_ticks = 0; ext_h = 1'b1; step(GS);
      @(negedge clk);
      chk(rst_out === 0, "R3", "not yet asserted during filter", int'(rst_out), 0);
      step(1);
      @(negedge clk);
      chk(rst_out === 1, "R3", "asserted after filter", int'(rst_out), 1);
      step(1); ext_h = 1'b0;
      wait_release(t);
      chk(t == PT, "R3", "pad-high pulse ticks", t, PT);

      // R4: low pad request
      step(5); asrt_ticks = 0; ext_l = 1'b0; step(GS);
      @(negedge clk);
      chk(rst_out === 0, "R4", "not yet asserted during filter", int'(rst_out), 0);
      step(1);
      @(negedge clk);
      chk(rst_out === 1, "R4", "asserted after filter", int'(rst_out), 1);
      step(1); ext_l = 1'b1;
      wait_release(t);
      chk(t == PT, "R4", "pad-low pulse ticks", t, PT);

      // R5: watchdog request
      step(5); wdog = 1'b1; step(1); wdog = 1'b0; asrt_ticks = 0;
      @(negedge clk);
      chk(rst_out === 1, "R5", "asserted after watchdog", int'(rst_out), 1);
      wait_release(t);
      chk(t == PT, "R5", "watchdog pulse ticks", t, PT);

      // R7: reload during an active pulse
      step(5); wdog = 1'b1; step(1); wdog = 1'b0;
      step(25); wdog = 1'b1; step(1); wdog = 1'b0; asrt_ticks = 0;
      wait_release(t);
      chk(t == PT, "R7", "ticks after reload", t, PT);

      // R1: supply drop while idle, then recovery
      step(5); supply_ok = 1'b0;
      @(negedge clk);
      chk(rst_out === 1 && rstn_out === 0, "R1", "immediate assert on supply drop",
          int'(rst_out), 1);
      step(3); supply_ok = 1'b1; asrt_ticks = 0;
      wait_release(t);
      chk(t == PT, "R2", "pulse after supply recovery", t, PT);

      // Random phase, compared against the model every cycle
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 15) == 0) ext_h = ~ext_h;
         if ($urandom_range(0, 15) == 0) ext_l = ~ext_l;
         wdog = ($urandom_range(0, 299) == 0);
         supply_ok = ($urandom_range(0, 1499) != 0);
         step(1);
      end
      wdog = 1'b0; supply_ok = 1'b1; ext_h = 1'b0; ext_l = 1'b1;
      step(4);
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

endmodule